// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block makes the count-enable strobe for one timer counter. It runs on the system clock and asserts `cnt_en` for one clock for every event that should advance the counter. A free-running prescaler gives internal rates of the system clock divided by 1, 4, 16 and 64. Four asynchronous external clock pins are synchronised and edge-detected. A 3-bit source field picks one of these eight sources, and a 2-bit edge field picks which transitions of the chosen source count.

Two overrides sit above the source field. When the cascade input is selected, each cycle in which the other channel's overflow/underflow event is high gives exactly one count. When phase-counting mode is active, the block passes an externally decoded phase-count enable straight through. In both cases the edge field is ignored, and phase-counting mode wins over cascade. The counter, compare/capture logic and register decoding live outside this block.

Top module: `tmr_cnt_en_sel`

## Requirements
- R1: While `rst_n` is low, `cnt_en` is 0, and the prescaler restarts from zero. After `rst_n` rises, with divide-by-4 on rising edges selected, the first pulse is seen after the fifth rising clock edge that follows the release, and there is none before it.
- R2: `psc_sel` encoding: 000 selects the undivided clock, 001 divide-by-4, 010 divide-by-16 and 011 divide-by-64. Values 100, 101, 110 and 111 select external pins `ext_clk[0]`, `[1]`, `[2]` and `[3]`.
- R3: `edge_sel` encoding: 00 counts rising (0 to 1) transitions, 01 counts falling (1 to 0) transitions, and 10 or 11 counts both. With a single edge, a divide-by-N source gives exactly one pulse per N cycles.
- R4: Counting on both edges doubles the rate. Divide-by-4 on both edges gives one pulse every 2 cycles, which is 32 pulses in any 64 cycles.
- R5: With `psc_sel` = 000, `cnt_en` is high every cycle, whatever `edge_sel` holds.
- R6: Each external pin passes through a two-flop synchroniser. A pin level present at a rising clock edge yields its one-cycle pulse just after the third rising edge, counting that first edge as one.
- R7: With `cascade_sel` high and phase mode off, `cnt_en` copies `cascade_evt` one cycle later, so each cycle that `cascade_evt` is high gives exactly one count. `edge_sel` and `psc_sel` have no effect.
- R8: With `phase_mode` high, `cnt_en` copies `phase_cnt_en` one cycle later. This overrides the cascade input, the source field and the edge field.
- R9: Pins that are not selected have no effect. Switching from one source to another never creates a pulse from a level difference between the two sources.
- R10: A change to `psc_sel`, `edge_sel` or an override input that is present at a clock edge governs `cnt_en` from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psc_sel | input | 3 | Count source select |
| edge_sel | input | 2 | Edge select: rise, fall, both |
| cascade_sel | input | 1 | Count on another channel's overflow/underflow |
| cascade_evt | input | 1 | Single-cycle overflow/underflow event of the other channel |
| phase_mode | input | 1 | Phase-counting mode active |
| phase_cnt_en | input | 1 | Count enable from the phase decoder |
| ext_clk | input | 4 | Asynchronous external clock pins |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The assertions assume that `psc_sel`, `edge_sel`, `cascade_sel` and `phase_mode` only change between clock edges and are known whenever reset is released. They also assume that `cascade_evt` and `phase_cnt_en` are already synchronous pulses. The no-repeat check on single-edge sources holds only while the configuration is held for two edges in a row, so its antecedent requires stability. The stimulus drives every input on the falling clock edge and holds each configuration for whole measurement windows. It toggles the external pins no faster than every eight cycles, so each synchronised level lasts long enough to be seen.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int SEL_W   = 3;
  localparam int EDGE_W  = 2;
  localparam int NUM_INT = 4;   // internal rates: /1 /4 /16 /64
  localparam int NUM_EXT = 4;   // external pins
  localparam int LOG_STEP = 2;  // each internal rate is 4x slower than the previous one

  typedef enum logic [EDGE_W-1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    SRC_FIELD   = 2'b00,
    SRC_CASCADE = 2'b01,
    SRC_PHASE   = 2'b10
  } src_class_e;

endpackage

// File: rtl/tcs_rst_sync.sv
module tcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int NUM_INT  = 4,
  parameter int LOG_STEP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_INT-2:0] taps
);

  localparam int PSC_W = LOG_STEP * (NUM_INT - 1);

  logic [PSC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Divided-clock k+1 is the top bit of the k-th group of LOG_STEP bits
  for (genvar k = 0; k < NUM_INT - 1; k++) begin : g_tap
    assign taps[k] = cnt_q[LOG_STEP*(k+1)-1];
  end

  // R2: the fastest divided clock keeps each level for exactly two cycles
  a_r2_div4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (taps[0] != $past(taps[0])) |=> $stable(taps[0]));

endmodule

// File: rtl/tcs_ext_sync.sv
module tcs_ext_sync #(
  parameter int NUM_EXT = 4,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] pin_async,
  output logic [NUM_EXT-1:0] pin_sync
);

  for (genvar p = 0; p < NUM_EXT; p++) begin : g_pin
    logic [STAGES-1:0] st_q, st_d;

    always_comb begin
      st_d = {st_q[STAGES-2:0], pin_async[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
    end

    assign pin_sync[p] = st_q[STAGES-1];
  end

endmodule

// File: rtl/tcs_edge_det.sv
module tcs_edge_det #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl,
  output logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] fall
);

  // One history bit per source, updated every cycle whether selected or not,
  // so a change of selection never compares levels of two different sources.
  logic [NUM_SRC-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = lvl;
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R9: a single-direction edge on any source is never reported two cycles running
  a_r9_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
  a_r9_fall_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((fall & $past(fall)) == '0));

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
#(
  parameter int SRC_N = 8
) (
  input  logic [SEL_W-1:0]  psc_sel,
  input  logic [EDGE_W-1:0] edge_sel,
  input  logic              cascade_sel,
  input  logic              cascade_evt,
  input  logic              phase_mode,
  input  logic              phase_cnt_en,
  input  logic [SRC_N-1:0]  rise_all,
  input  logic [SRC_N-1:0]  fall_all,
  output logic              en_nxt
);

  src_class_e cls;
  logic       field_en;

  always_comb begin
    if (phase_mode)       cls = SRC_PHASE;
    else if (cascade_sel) cls = SRC_CASCADE;
    else                  cls = SRC_FIELD;
  end

  always_comb begin
    case (edge_mode_e'(edge_sel))
      EDGE_RISE: field_en = rise_all[psc_sel];
      EDGE_FALL: field_en = fall_all[psc_sel];
      default:   field_en = rise_all[psc_sel] | fall_all[psc_sel];
    endcase
  end

  always_comb begin
    case (cls)
      SRC_PHASE:   en_nxt = phase_cnt_en;
      SRC_CASCADE: en_nxt = cascade_evt;
      default:     en_nxt = field_en;
    endcase
  end

endmodule

// File: rtl/tmr_cnt_en_sel.sv
module tmr_cnt_en_sel
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  psc_sel,
  input  logic [EDGE_W-1:0] edge_sel,
  input  logic              cascade_sel,
  input  logic              cascade_evt,
  input  logic              phase_mode,
  input  logic              phase_cnt_en,
  input  logic [NUM_EXT-1:0] ext_clk,
  output logic              cnt_en
);

  localparam int NUM_DIV = NUM_INT - 1;
  localparam int NUM_SRC = NUM_DIV + NUM_EXT;
  localparam int SRC_N   = NUM_SRC + 1;

  logic               rst_sync_n;
  logic [NUM_DIV-1:0] taps;
  logic [NUM_EXT-1:0] pin_sync;
  logic [NUM_SRC-1:0] rise, fall;
  logic [SRC_N-1:0]   rise_all, fall_all;
  logic               en_nxt;
  logic               cnt_en_q;

  tcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tcs_prescaler #(.NUM_INT(NUM_INT), .LOG_STEP(LOG_STEP)) u_psc (
    .clk(clk), .rst_n(rst_sync_n), .taps(taps)
  );

  tcs_ext_sync #(.NUM_EXT(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_async(ext_clk), .pin_sync(pin_sync)
  );

  tcs_edge_det #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl({pin_sync, taps}),
    .rise(rise), .fall(fall)
  );

  // Index 0 is the undivided clock: an event every cycle on every edge setting
  assign rise_all = {rise, 1'b1};
  assign fall_all = {fall, 1'b1};

  tcs_src_mux #(.SRC_N(SRC_N)) u_mux (
    .psc_sel(psc_sel), .edge_sel(edge_sel),
    .cascade_sel(cascade_sel), .cascade_evt(cascade_evt),
    .phase_mode(phase_mode), .phase_cnt_en(phase_cnt_en),
    .rise_all(rise_all), .fall_all(fall_all), .en_nxt(en_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_en_q <= 1'b0;
    else             cnt_en_q <= en_nxt;
  end

  assign cnt_en = cnt_en_q;

  // R5: undivided clock counts every cycle
  a_r5_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (psc_sel == '0 && !phase_mode && !cascade_sel) |=> cnt_en);

  // R8: phase-counting pass-through has top priority
  a_r8_phase_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_mode |=> (cnt_en == $past(phase_cnt_en)));

  // R7: one count per cascade event
  a_r7_cascade_one_per_event: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!phase_mode && cascade_sel) |=> (cnt_en == $past(cascade_evt)));

  // R3: a single-edge divided or pin source never pulses two cycles running
  a_r3_single_edge_no_repeat: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_en && !phase_mode && !$past(phase_mode) && !cascade_sel && !$past(cascade_sel)
     && psc_sel != '0 && !edge_sel[1] && $stable(psc_sel) && $stable(edge_sel))
    |=> !cnt_en);

endmodule

// File: tb/tb_tmr_cnt_en_sel.sv
module tb_tmr_cnt_en_sel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] psc_sel;
  logic [1:0] edge_sel;
  logic       cascade_sel, cascade_evt, phase_mode, phase_cnt_en;
  logic [3:0] ext_clk;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  tmr_cnt_en_sel dut (
    .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .edge_sel(edge_sel),
    .cascade_sel(cascade_sel), .cascade_evt(cascade_evt),
    .phase_mode(phase_mode), .phase_cnt_en(phase_cnt_en),
    .ext_clk(ext_clk), .cnt_en(cnt_en)
  );

  always @(negedge clk) if (cnt_en === 1'b1) pulses <= pulses + 1;

  // {psc[14:12], edge[11:10], phase[9], cascade[8], expected pulses in 64 cycles[7:0]}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {3'b000, 2'b00, 1'b0, 1'b0, 8'd64},
    {3'b000, 2'b01, 1'b0, 1'b0, 8'd64},
    {3'b000, 2'b10, 1'b0, 1'b0, 8'd64},
    {3'b001, 2'b00, 1'b0, 1'b0, 8'd16},
    {3'b001, 2'b01, 1'b0, 1'b0, 8'd16},
    {3'b001, 2'b11, 1'b0, 1'b0, 8'd32},
    {3'b010, 2'b00, 1'b0, 1'b0, 8'd4},
    {3'b010, 2'b01, 1'b0, 1'b0, 8'd4},
    {3'b010, 2'b10, 1'b0, 1'b0, 8'd8},
    {3'b011, 2'b00, 1'b0, 1'b0, 8'd1},
    {3'b011, 2'b01, 1'b0, 1'b0, 8'd1},
    {3'b011, 2'b11, 1'b0, 1'b0, 8'd2},
    {3'b100, 2'b00, 1'b0, 1'b0, 8'd0},
    {3'b000, 2'b00, 1'b1, 1'b0, 8'd0},
    {3'b000, 2'b10, 1'b0, 1'b1, 8'd0}
  };

  function automatic string tag_of(logic [14:0] v);
    if (v[9])                  return "R8";
    if (v[8])                  return "R7";
    if (v[14:12] == 3'b000)    return "R5";
    if (v[14])                 return "R9";
    if (v[11])                 return "R4";
    return "R3";
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic snap(output int v);
    @(posedge clk); #1 v = pulses;
  endtask

  task automatic toggle_pin(int idx, int half, int periods);
    for (int i = 0; i < periods; i++) begin
      repeat (half) @(negedge clk);
      ext_clk[idx] = 1'b1;
      repeat (half) @(negedge clk);
      ext_clk[idx] = 1'b0;
    end
  endtask

  task automatic set_cfg(logic [2:0] p, logic [1:0] e, logic ph, logic cs);
    @(negedge clk);
    psc_sel = p; edge_sel = e; phase_mode = ph; cascade_sel = cs;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b;
    rst_n = 1'b0; psc_sel = 3'b001; edge_sel = 2'b00;
    cascade_sel = 0; cascade_evt = 0; phase_mode = 0; phase_cnt_en = 0;
    ext_clk = '0;

    // R1: quiet in reset, prescaler restarts on release
    repeat (3) @(negedge clk);
    check("R1 in reset", cnt_en, 0);
    rst_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check($sformatf("R1 release cycle %0d", i), cnt_en, 0);
    end
    @(negedge clk);
    check("R1 first div4 pulse", cnt_en, 1);

    // R2 R3 R4 R5 R7 R8: vector table, pulses per 64-cycle window
    for (int r = 0; r < NV; r++) begin
      set_cfg(VEC[r][14:12], VEC[r][11:10], VEC[r][9], VEC[r][8]);
      repeat (4) @(posedge clk);
      snap(a);
      repeat (64) @(posedge clk);
      #1 b = pulses;
      check($sformatf("%s R2 row %0d", tag_of(VEC[r]), r), b - a, int'(VEC[r][7:0]));
    end

    // R10: source change applies from the next edge
    set_cfg(3'b000, 2'b00, 0, 0);
    repeat (3) @(negedge clk);
    set_cfg(3'b100, 2'b00, 0, 0);
    @(negedge clk);
    check("R10 switch off div1", cnt_en, 0);

    // R6: synchroniser latency on pin 0, rising edge
    repeat (4) @(negedge clk);
    ext_clk[0] = 1'b1;
    @(negedge clk); check("R6 latency 1", cnt_en, 0);
    @(negedge clk); check("R6 latency 2", cnt_en, 0);
    @(negedge clk); check("R6 latency 3", cnt_en, 1);
    @(negedge clk); check("R6 pulse width", cnt_en, 0);
    ext_clk[0] = 1'b0;
    repeat (6) @(negedge clk);

    // R2 R3: pin 2 rising, pin 3 falling; R4: pin 1 both edges
    set_cfg(3'b110, 2'b00, 0, 0);
    snap(a); toggle_pin(2, 8, 4); repeat (6) @(posedge clk); #1 b = pulses;
    check("R3 R2 pin2 rising", b - a, 4);
    set_cfg(3'b111, 2'b01, 0, 0);
    snap(a); toggle_pin(3, 8, 4); repeat (6) @(posedge clk); #1 b = pulses;
    check("R3 R2 pin3 falling", b - a, 4);
    set_cfg(3'b101, 2'b10, 0, 0);
    snap(a); toggle_pin(1, 8, 4); repeat (6) @(posedge clk); #1 b = pulses;
    check("R4 pin1 both edges", b - a, 8);

    // R9: unselected pin ignored
    set_cfg(3'b100, 2'b10, 0, 0);
    snap(a); toggle_pin(1, 8, 3); repeat (6) @(posedge clk); #1 b = pulses;
    check("R9 unselected pin", b - a, 0);

    // R9: switching from a low pin to a high pin gives no pulse
    set_cfg(3'b101, 2'b00, 0, 0);
    ext_clk[0] = 1'b1;
    repeat (8) @(negedge clk);
    snap(a);
    set_cfg(3'b100, 2'b00, 0, 0);
    repeat (10) @(posedge clk); #1 b = pulses;
    check("R9 switch no spurious", b - a, 0);
    ext_clk[0] = 1'b0;
    repeat (6) @(negedge clk);

    // R7: cascade events, edge field ignored
    set_cfg(3'b001, 2'b01, 0, 1);
    repeat (3) @(negedge clk);
    snap(a);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) cascade_evt = 1'b1;
      @(negedge clk) cascade_evt = 1'b0;
      repeat (2) @(negedge clk);
    end
    @(negedge clk) cascade_evt = 1'b1;
    repeat (3) @(negedge clk);
    cascade_evt = 1'b0;
    repeat (4) @(posedge clk); #1 b = pulses;
    check("R7 cascade count", b - a, 8);

    // R8: phase mode overrides cascade and source field
    set_cfg(3'b000, 2'b00, 1, 1);
    cascade_evt = 1'b1;
    @(negedge clk); phase_cnt_en = 1'b1;
    @(negedge clk); check("R8 follows enable", cnt_en, 1);
    phase_cnt_en = 1'b0;
    @(negedge clk); check("R8 ignores div1 and cascade", cnt_en, 0);
    cascade_evt = 1'b0;

    // R1: asynchronous reset mid-run
    set_cfg(3'b000, 2'b00, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async clear", cnt_en, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); check("R1 held after release", cnt_en, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule